// File: doc/BRIEF.md
# Event Fragment Framer

The framer turns a stream of 64-bit detector payload words into a self-describing fragment. A fragment is a control-flagged header word, then the payload words unchanged and flagged as data, then a control-flagged trailer word. The header identifies the event: its type, the level-1 trigger number, the bunch-crossing number, the source identifier, a format-version nibble and a header-continuation bit. The trailer closes the fragment with the total word count, a 16-bit CRC and an event status byte.

Payload arrives on a valid/ready interface with a last-word flag. The first offered word of a fragment causes the header to be emitted before that word is accepted. The word that carries the last flag causes the trailer to be emitted after it. The output is a valid/ready stream with one control/data flag per word. Backpressure from the output reaches the input directly, and the input is held off while the header or the trailer is on the output.

Top module: `frag_framer`

## Requirements
- R1: While reset is applied, and until a payload word is offered after it, `out_valid` and `in_ready` are 0.
- R2: A fragment begins with one word that has `out_ctrl`=1. Its fields are: bits 63:60 = 0x5, bits 59:56 = `evt_type`, bits 55:32 = `trig_num`, bits 31:20 = `bx_num`, bits 19:8 = `src_id`, bits 7:4 = parameter FMT_VER, bit 3 = parameter HDR_CONT, and bits 2:0 = 0. The metadata inputs are taken while the first payload word is being offered.
- R3: Each accepted payload word appears on `out_data` unchanged and in order, with `out_ctrl`=0.
- R4: The word after the payload word that has `in_last`=1 is a trailer with `out_ctrl`=1. Bits 63:60 of the trailer are 0xA, and bits 59:56, 15:12 and 3:0 are 0.
- R5: Trailer bits 55:32 hold the number of words in the fragment, header and trailer included (payload + 2).
- R6: Trailer bits 31:16 hold a CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is taken over the header and then every payload word, each word processed most significant bit first. The CRC restarts for each fragment.
- R7: Trailer bits 11:4 hold the value `evt_status` had when the last payload word was accepted. Later changes to `evt_status` do not alter it.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_ctrl` stay unchanged on the next cycle and `out_valid` stays 1.
- R9: `in_ready` is 1 only while payload is being passed through, and it then equals `out_ready`. It is 0 while a header or a trailer is on the output.
- R10: Fragments with a one-word payload and fragments that start in the cycle after the previous trailer is accepted are framed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_type | input | 4 | Event type for the header |
| trig_num | input | 24 | Level-1 trigger number |
| bx_num | input | 12 | Bunch-crossing number |
| src_id | input | 12 | Source identifier |
| evt_status | input | 8 | Status byte, captured with the last payload word |
| in_valid | input | 1 | Payload word offered |
| in_ready | output | 1 | Payload word accepted |
| in_data | input | 64 | Payload word |
| in_last | input | 1 | Marks the last payload word of a fragment |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 64 | Output word |
| out_ctrl | output | 1 | 1 for header and trailer, 0 for payload |

## Verification
The bench builds the framer with FMT_VER = 0x9 and HDR_CONT = 1. Non-default values in both fields make the version nibble and the continuation bit visible in every header, and a field placed at the wrong position shows up as a mismatch. CRC_EN is left at 1, so the trailer CRC is compared against an independent byte-wise CRC model across payloads of 1 to 20 words. The bench also varies output stall patterns and input gaps, and it changes the status input around the last word.

// File: rtl/frag_pkg.sv
package frag_pkg;
   localparam int WORD_W   = 64;
   localparam int LEN_W    = 24;
   localparam int CRC_W    = 16;
   localparam logic [3:0] HDR_MARK = 4'h5;
   localparam logic [3:0] TRL_MARK = 4'hA;

   typedef enum logic [1:0] {PH_IDLE, PH_PAY, PH_TRL} phase_e;

   // Bit-serial CRC over one word, most significant bit first
   function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c_in,
                                                 input logic [WORD_W-1:0] w,
                                                 input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] c;
      logic fb;
      c = c_in;
      for (int i = WORD_W-1; i >= 0; i--) begin
         fb = c[CRC_W-1] ^ w[i];
         c  = {c[CRC_W-2:0], 1'b0};
         if (fb) c = c ^ poly;
      end
      return c;
   endfunction
endpackage

// File: rtl/frag_word_fmt.sv
module frag_word_fmt
   import frag_pkg::*;
#(
   parameter logic [3:0] FMT_VER  = 4'h1,
   parameter bit         HDR_CONT = 1'b0
) (
   input  logic [3:0]        evt_type,
   input  logic [23:0]       trig_num,
   input  logic [11:0]       bx_num,
   input  logic [11:0]       src_id,
   input  logic [LEN_W-1:0]  frag_len,
   input  logic [CRC_W-1:0]  frag_crc,
   input  logic [7:0]        frag_stat,
   output logic [WORD_W-1:0] hdr_word,
   output logic [WORD_W-1:0] trl_word
);
   always_comb begin
      hdr_word = {HDR_MARK, evt_type, trig_num, bx_num, src_id,
                  FMT_VER, HDR_CONT, 3'b000};
      trl_word = {TRL_MARK, 4'h0, frag_len, frag_crc, 4'h0, frag_stat, 4'h0};
   end
endmodule

// File: rtl/frag_crc_acc.sv
module frag_crc_acc
   import frag_pkg::*;
#(
   parameter bit               CRC_EN   = 1'b1,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              upd,
   input  logic [WORD_W-1:0] word,
   output logic [CRC_W-1:0]  crc
);
   if (CRC_EN) begin : g_crc
      logic [CRC_W-1:0] crc_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) crc_q <= CRC_INIT;
         else if (upd)      crc_q <= crc_word(crc_q, word, CRC_POLY);
      end
      assign crc = crc_q;
   end else begin : g_nocrc
      logic unused_crc_in;
      assign unused_crc_in = ^{clk, rst_n, clr, upd, word};
      assign crc = '0;
   end
endmodule

// File: rtl/frag_framer.sv
module frag_framer
   import frag_pkg::*;
#(
   parameter int               DATA_W   = 64,
   parameter logic [3:0]       FMT_VER  = 4'h1,
   parameter bit               HDR_CONT = 1'b0,
   parameter bit               CRC_EN   = 1'b1,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        evt_type,
   input  logic [23:0]       trig_num,
   input  logic [11:0]       bx_num,
   input  logic [11:0]       src_id,
   input  logic [7:0]        evt_status,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_ctrl
);
   localparam logic [LEN_W-1:0] FRAME_OVH = LEN_W'(2);

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("frag_framer: DATA_W must equal the 64-bit fragment word width");
   end
   if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
      $error("frag_framer: CRC_POLY must have its constant term set");
   end

   phase_e            phase_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [7:0]        stat_q;
   logic [CRC_W-1:0]  crc_cur;
   logic [WORD_W-1:0] hdr_word, trl_word;
   logic              hdr_fire, pay_fire, trl_fire;

   assign hdr_fire = (phase_q == PH_IDLE) && in_valid && out_ready;
   assign pay_fire = (phase_q == PH_PAY)  && in_valid && out_ready;
   assign trl_fire = (phase_q == PH_TRL)  && out_ready;

   frag_word_fmt #(.FMT_VER(FMT_VER), .HDR_CONT(HDR_CONT)) i_fmt (
      .evt_type (evt_type),
      .trig_num (trig_num),
      .bx_num   (bx_num),
      .src_id   (src_id),
      .frag_len (cnt_q + FRAME_OVH),
      .frag_crc (crc_cur),
      .frag_stat(stat_q),
      .hdr_word (hdr_word),
      .trl_word (trl_word)
   );

   frag_crc_acc #(.CRC_EN(CRC_EN), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) i_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (trl_fire),
      .upd  (hdr_fire || pay_fire),
      .word (out_data),
      .crc  (crc_cur)
   );

   always_comb begin
      unique case (phase_q)
         PH_IDLE: begin
            out_valid = in_valid;
            out_ctrl  = 1'b1;
            out_data  = hdr_word;
         end
         PH_PAY: begin
            out_valid = in_valid;
            out_ctrl  = 1'b0;
            out_data  = in_data;
         end
         default: begin
            out_valid = 1'b1;
            out_ctrl  = 1'b1;
            out_data  = trl_word;
         end
      endcase
      in_ready = (phase_q == PH_PAY) && out_ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         stat_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (hdr_fire) phase_q <= PH_PAY;
            PH_PAY: if (pay_fire) begin
               cnt_q <= cnt_q + LEN_W'(1);
               if (in_last) begin
                  stat_q  <= evt_status;
                  phase_q <= PH_TRL;
               end
            end
            default: if (trl_fire) begin
               cnt_q   <= '0;
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

   // R9
   ready_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !out_ctrl);

   // R2
   hdr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_fire |=> (phase_q == PH_PAY && cnt_q == '0));

   // R4
   trl_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_fire && in_last) |=> (out_valid && out_ctrl && !in_ready));

   // R5
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trl_fire |=> (cnt_q == '0 && phase_q == PH_IDLE));
endmodule

// File: tb/test_frag_framer.sv
module test_frag_framer;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [3:0] TB_VER  = 4'h9;
   localparam bit         TB_CONT = 1'b1;
   localparam int K_HDR = 0, K_DAT = 1, K_TRL = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0] evt_type = '0;
   logic [23:0] trig_num = '0;
   logic [11:0] bx_num = '0, src_id = '0;
   logic [7:0] evt_status = '0;
   logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
   logic [63:0] in_data = '0;
   logic in_ready, out_valid, out_ctrl;
   logic [63:0] out_data;

   int checks = 0, errors = 0, cyc = 0;
   int ready_pct = 100;
   int exp_kind[$];
   logic [63:0] exp_word[$];

   frag_framer #(.FMT_VER(TB_VER), .HDR_CONT(TB_CONT)) i_frag_framer (
      .clk(clk), .rst_n(rst_n), .evt_type(evt_type), .trig_num(trig_num),
      .bx_num(bx_num), .src_id(src_id), .evt_status(evt_status),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ctrl(out_ctrl)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] ref_crc(logic [15:0] c, logic [63:0] w);
      for (int b = 7; b >= 0; b--) begin
         c = c ^ {w[b*8 +: 8], 8'h00};
         for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
      return c;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Reference comparison on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
         end
         // R9: input accepted only in payload phase, following out_ready
         check("R9 in_ready", {63'd0, in_ready},
               {63'd0, (exp_kind.size() > 0 && exp_kind[0] == K_DAT) ? out_ready : 1'b0});
         if (out_valid) begin
            if (exp_kind.size() == 0) begin
               check("R1 R10 unexpected word", {63'd0, out_valid}, 64'd0);
            end else if (!out_ready) begin
               check("R8 stalled word", out_data, exp_word[0]);
               check("R8 stalled flag", {63'd0, out_ctrl}, {63'd0, exp_kind[0] != K_DAT});
            end else begin
               check(exp_kind[0] == K_DAT ? "R3 flag" : "R2 R4 flag",
                     {63'd0, out_ctrl}, {63'd0, exp_kind[0] != K_DAT});
               if (exp_kind[0] == K_HDR) check("R2 header", out_data, exp_word[0]);
               else if (exp_kind[0] == K_DAT) check("R3 payload", out_data, exp_word[0]);
               else begin
                  check("R4 trailer fixed bits", out_data & 64'hFF00_0000_0000_F00F,
                        exp_word[0] & 64'hFF00_0000_0000_F00F);
                  check("R5 length", {40'd0, out_data[55:32]}, {40'd0, exp_word[0][55:32]});
                  check("R6 crc", {48'd0, out_data[31:16]}, {48'd0, exp_word[0][31:16]});
                  check("R7 status", {56'd0, out_data[11:4]}, {56'd0, exp_word[0][11:4]});
               end
               void'(exp_kind.pop_front());
               void'(exp_word.pop_front());
            end
         end
      end
   end

   // Output backpressure pattern
   initial forever begin
      @(posedge clk); #1;
      out_ready = (($urandom % 100) < ready_pct);
   end

   task automatic send_frag(int n, int gap);
      logic [63:0] pay[$];
      logic [63:0] hdr;
      logic [15:0] c;
      logic [7:0] st_early, st_final;
      logic fire;
      evt_type = 4'($urandom); trig_num = 24'($urandom);
      bx_num = 12'($urandom); src_id = 12'($urandom);
      st_early = 8'($urandom); st_final = ~st_early;
      hdr = {4'h5, evt_type, trig_num, bx_num, src_id, TB_VER, TB_CONT, 3'b000};
      c = ref_crc(16'hFFFF, hdr);
      exp_kind.push_back(K_HDR); exp_word.push_back(hdr);
      for (int i = 0; i < n; i++) begin
         pay.push_back({$urandom, $urandom});
         c = ref_crc(c, pay[i]);
         exp_kind.push_back(K_DAT); exp_word.push_back(pay[i]);
      end
      exp_kind.push_back(K_TRL);
      exp_word.push_back({4'hA, 4'h0, 24'(n + 2), c, 4'h0, st_final, 4'h0});
      evt_status = st_early;
      for (int i = 0; i < n; i++) begin
         while (int'($urandom % 4) < gap) begin
            in_valid = 1'b0; @(posedge clk); #1;
         end
         in_valid = 1'b1; in_data = pay[i]; in_last = (i == n - 1);
         if (i == n - 1) evt_status = st_final;
         do begin
            @(negedge clk); fire = in_ready;
            @(posedge clk); #1;
         end while (!fire);
      end
      in_valid = 1'b0; in_last = 1'b0;
      evt_status = 8'($urandom); // R7: later change must not reach the trailer
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      @(negedge clk);
      check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
      check("R1 reset in_ready", {63'd0, in_ready}, 64'd0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
      @(posedge clk); #1;
      // R10: single-word and back-to-back fragments at full rate
      send_frag(1, 0);
      send_frag(1, 0);
      send_frag(4, 0);
      // stalls on the output
      ready_pct = 50;
      send_frag(1, 0);
      send_frag(7, 1);
      send_frag(3, 0);
      ready_pct = 25;
      send_frag(5, 2);
      send_frag(1, 3);
      ready_pct = 100;
      send_frag(12, 2);
      for (int f = 0; f < 25; f++) begin
         ready_pct = 30 + int'($urandom % 71);
         send_frag(1 + int'($urandom % 20), int'($urandom % 3));
      end
      while (exp_kind.size() > 0) @(posedge clk);
      repeat (3) @(posedge clk);
      summary();
   end
endmodule